// File: doc/BRIEF.md
# Interrupt Controller Global Control and Soft Reset

This block is the global control slice of a small programmable interrupt controller. It holds two configuration words on a simple synchronous register bus. The global word carries a self-clearing soft-reset bit and the operating-mode bit. The interrupt configuration word carries the serial clock ratio and the serial/direct select. The block does no priority arbitration and no serial decoding. It only tells those neighbouring blocks what to do, with select outputs and clear strobes.

Writing the soft-reset bit starts a fixed four-cycle sequence. Each cycle raises the strobe for one group of state held elsewhere in the controller. The first cycle clears the pending and in-service bits. The second sets every mask bit. The third zeroes and halts the timer base counts. The fourth loads the current task priority with `TASK_PRI_DFLT` (0xF, which blocks delivery) and the spurious vector with `SPUR_VEC_DFLT` (0xFF); both constants come from the package. When the sequence ends, the block puts itself back into pass-through mode and reloads a serial ratio of 4. Every other field keeps its programmed value.

The block also steers the processor interrupt line. In pass-through mode the external input `irq0_in` drives that line with no register on the way. In mixed mode the select bit picks either the direct-delivery result or the serial-delivery result.

Top module: `irqc_global_ctl`

## Requirements
- R1: After hardware reset (`rst` high at a clock edge), the global word (address 0) reads 0x0000_0000 and the configuration word (address 1) reads 0x4000_0000, meaning ratio 4 and select 0. All six sequence strobes are low, `ctrl_en_o` is 0 and `ser_ratio_o` is 4.
- R2: A bus write to address 0 with bit 31 set starts the soft reset. Bit 31 of address 0 reads 1 in the four cycles that follow the write edge, and reads 0 after that.
- R3: The sequence strobes come in a fixed order, each high for exactly one cycle. Cycle 1 raises `clr_pend_o` and `clr_insvc_o`. Cycle 2 raises `set_mask_o`. Cycle 3 raises `tmr_halt_o`. Cycle 4 raises `prio_load_o` and `spur_load_o`. No strobe is high outside a sequence.
- R4: When the sequence completes, the mode bit is 0 (pass-through) and the ratio field is 4. The select bit (bit 27) keeps its earlier value.
- R5: While a sequence runs, every bus write is ignored, including a second write of the reset bit. Reads still work.
- R6: The mode bit is bit 29 of address 0 and can be read and written (0 = pass-through, 1 = mixed). Every other bit of address 0 except bit 31 reads 0, whatever was written to it.
- R7: At address 1, bits 30:28 hold the serial ratio and bit 27 holds the serial select; both can be read and written. All other bits read 0. `ser_ratio_o` always shows the ratio field.
- R8: With mode 0, `cpu_int_o` follows `irq0_in` combinationally, and `ctrl_en_o` and `serial_sel_o` are 0.
- R9: With mode 1, `ctrl_en_o` is 1 and `serial_sel_o` equals the select bit. `cpu_int_o` equals `direct_int_in` when the select bit is 0 and `serial_int_in` when it is 1.
- R10: A write to any address other than 0 or 1 has no effect, and such an address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_addr | input | ADDR_W | Word address of the register bus |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq0_in | input | 1 | External active-high interrupt used in pass-through mode |
| direct_int_in | input | 1 | Interrupt request from the direct-delivery arbiter |
| serial_int_in | input | 1 | Interrupt request from the serial-delivery path |
| cpu_int_o | output | 1 | Interrupt to the processor |
| ctrl_en_o | output | 1 | Controller enabled (mixed mode) |
| serial_sel_o | output | 1 | Serial delivery selected while in mixed mode |
| ser_ratio_o | output | 3 | Serial clock ratio for the serial decoder |
| clr_pend_o | output | 1 | Sequence strobe: clear pending bits |
| clr_insvc_o | output | 1 | Sequence strobe: clear in-service bits |
| set_mask_o | output | 1 | Sequence strobe: set all mask bits |
| tmr_halt_o | output | 1 | Sequence strobe: zero and inhibit timer base counts |
| prio_load_o | output | 1 | Sequence strobe: load task priority default |
| spur_load_o | output | 1 | Sequence strobe: load spurious vector default |

## Verification
The hardest case to reach is bus traffic that arrives while a soft reset is still running. A write there must change nothing, and a second reset write must not extend or restart the sequence. To get there, the bench starts a sequence from a known non-default setup: mixed mode, ratio 5, select 1. On the following falling edges it drives a configuration write and then another reset write, and it checks the strobes one cycle at a time. After the sequence it confirms that the sequence lasted exactly four cycles, that mode and ratio were restored, and that the select bit kept its value of 1.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DATA_W        = 32;
    localparam int GCR_ADDR      = 0;
    localparam int ICR_ADDR      = 1;

    localparam int GCR_RST_BIT   = 31;
    localparam int GCR_MODE_BIT  = 29;
    localparam int RATIO_W       = 3;
    localparam int ICR_RATIO_LSB = 28;
    localparam int ICR_SIE_BIT   = 27;

    localparam logic [RATIO_W-1:0] RATIO_DFLT    = 3'd4;
    localparam logic [3:0]         TASK_PRI_DFLT = 4'hF;
    localparam logic [7:0]         SPUR_VEC_DFLT = 8'hFF;

    localparam int SEQ_LEN   = 4;
    localparam int STEP_CLR  = 0;
    localparam int STEP_MASK = 1;
    localparam int STEP_TMR  = 2;
    localparam int STEP_LOAD = 3;

    typedef enum logic {
        MODE_PASS  = 1'b0,
        MODE_MIXED = 1'b1
    } irq_mode_e;

    typedef struct packed {
        irq_mode_e mode;
    } gcr_t;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               sie;
    } icr_t;

    typedef struct packed {
        logic clr_pend;
        logic clr_insvc;
        logic set_mask;
        logic tmr_halt;
        logic prio_load;
        logic spur_load;
    } rst_act_t;

    function automatic rst_act_t step_actions(input logic [SEQ_LEN-1:0] step);
        rst_act_t a;
        a.clr_pend  = step[STEP_CLR];
        a.clr_insvc = step[STEP_CLR];
        a.set_mask  = step[STEP_MASK];
        a.tmr_halt  = step[STEP_TMR];
        a.prio_load = step[STEP_LOAD];
        a.spur_load = step[STEP_LOAD];
        return a;
    endfunction

    function automatic logic [DATA_W-1:0] pack_gcr(input logic busy, input gcr_t g);
        logic [DATA_W-1:0] r;
        r = '0;
        r[GCR_RST_BIT]  = busy;
        r[GCR_MODE_BIT] = g.mode;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pack_icr(input icr_t c);
        logic [DATA_W-1:0] r;
        r = '0;
        r[ICR_RATIO_LSB +: RATIO_W] = c.ratio;
        r[ICR_SIE_BIT]              = c.sie;
        return r;
    endfunction

endpackage

// File: rtl/irqc_rst_seq.sv
module irqc_rst_seq
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic [SEQ_LEN-1:0] step,
    output logic               busy,
    output logic               last
);

    logic [SEQ_LEN-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
        end else begin
            step_q[0] <= start;
        end
    end

    // each stage of the one-hot walker hands its token to the next
    for (genvar i = 1; i < SEQ_LEN; i++) begin : g_walk
        always_ff @(posedge clk) begin
            if (rst) begin
                step_q[i] <= 1'b0;
            end else begin
                step_q[i] <= step_q[i-1];
            end
        end
    end

    assign step = step_q;
    assign busy = |step_q;
    assign last = step_q[SEQ_LEN-1];

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              wr_rst_bit,
    input  logic              wr_mode_bit,
    input  logic [RATIO_W-1:0] wr_ratio,
    input  logic              wr_sie_bit,
    input  logic              busy,
    input  logic              last,
    output logic              start,
    output gcr_t              gcr,
    output icr_t              icr,
    output logic [DATA_W-1:0] rdata
);

    logic hit_gcr, hit_icr, wr_gcr, wr_icr;

    assign hit_gcr = (addr == ADDR_W'(GCR_ADDR));
    assign hit_icr = (addr == ADDR_W'(ICR_ADDR));
    assign wr_gcr  = we && hit_gcr && !busy;
    assign wr_icr  = we && hit_icr && !busy;
    assign start   = wr_gcr && wr_rst_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            gcr.mode  <= MODE_PASS;
            icr.ratio <= RATIO_DFLT;
            icr.sie   <= 1'b0;
        end else if (last) begin
            gcr.mode  <= MODE_PASS;
            icr.ratio <= RATIO_DFLT;
        end else begin
            if (wr_gcr && !wr_rst_bit) begin
                gcr.mode <= irq_mode_e'(wr_mode_bit);
            end
            if (wr_icr) begin
                icr.ratio <= wr_ratio;
                icr.sie   <= wr_sie_bit;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_gcr) begin
            rdata = pack_gcr(busy, gcr);
        end else if (hit_icr) begin
            rdata = pack_icr(icr);
        end
    end

endmodule

// File: rtl/irqc_route.sv
module irqc_route
    import irqc_pkg::*;
(
    input  irq_mode_e mode,
    input  logic      sie,
    input  logic      irq0_in,
    input  logic      direct_int_in,
    input  logic      serial_int_in,
    output logic      cpu_int,
    output logic      ctrl_en,
    output logic      serial_sel
);

    always_comb begin
        ctrl_en    = (mode == MODE_MIXED);
        serial_sel = ctrl_en && sie;
        unique case (mode)
            MODE_PASS:  cpu_int = irq0_in;
            MODE_MIXED: cpu_int = sie ? serial_int_in : direct_int_in;
            default:    cpu_int = irq0_in;
        endcase
    end

endmodule

// File: rtl/irqc_global_ctl.sv
module irqc_global_ctl
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              irq0_in,
    input  logic              direct_int_in,
    input  logic              serial_int_in,
    output logic              cpu_int_o,
    output logic              ctrl_en_o,
    output logic              serial_sel_o,
    output logic [2:0]        ser_ratio_o,
    output logic              clr_pend_o,
    output logic              clr_insvc_o,
    output logic              set_mask_o,
    output logic              tmr_halt_o,
    output logic              prio_load_o,
    output logic              spur_load_o
);

    logic               seq_start, seq_busy, seq_last;
    logic [SEQ_LEN-1:0] seq_step;
    gcr_t               gcr_q;
    icr_t               icr_q;
    rst_act_t           act;
    logic               unused_wdata_bits;

    assign unused_wdata_bits = ^{bus_wdata[30], bus_wdata[26:0]};

    irqc_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .addr        (bus_addr),
        .we          (bus_we),
        .wr_rst_bit  (bus_wdata[GCR_RST_BIT]),
        .wr_mode_bit (bus_wdata[GCR_MODE_BIT]),
        .wr_ratio    (bus_wdata[ICR_RATIO_LSB +: RATIO_W]),
        .wr_sie_bit  (bus_wdata[ICR_SIE_BIT]),
        .busy        (seq_busy),
        .last        (seq_last),
        .start       (seq_start),
        .gcr         (gcr_q),
        .icr         (icr_q),
        .rdata       (bus_rdata)
    );

    irqc_rst_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (seq_start),
        .step  (seq_step),
        .busy  (seq_busy),
        .last  (seq_last)
    );

    irqc_route u_route (
        .mode          (gcr_q.mode),
        .sie           (icr_q.sie),
        .irq0_in       (irq0_in),
        .direct_int_in (direct_int_in),
        .serial_int_in (serial_int_in),
        .cpu_int       (cpu_int_o),
        .ctrl_en       (ctrl_en_o),
        .serial_sel    (serial_sel_o)
    );

    assign act         = step_actions(seq_step);
    assign clr_pend_o  = act.clr_pend;
    assign clr_insvc_o = act.clr_insvc;
    assign set_mask_o  = act.set_mask;
    assign tmr_halt_o  = act.tmr_halt;
    assign prio_load_o = act.prio_load;
    assign spur_load_o = act.spur_load;
    assign ser_ratio_o = icr_q.ratio;

endmodule

// File: rtl/irqc_global_ctl_chk.sv
module irqc_global_ctl_chk
    import irqc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               seq_start,
    input logic [SEQ_LEN-1:0] seq_step,
    input logic               irq0_in,
    input logic               direct_int_in,
    input logic               serial_int_in,
    input logic               cpu_int_o,
    input logic               ctrl_en_o,
    input logic               serial_sel_o,
    input logic [2:0]         ser_ratio_o
);

    assert_step_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(seq_step));

    assert_start_enters_R2: assert property (@(posedge clk) disable iff (rst)
        seq_start |=> seq_step[0]);

    for (genvar i = 0; i < SEQ_LEN - 1; i++) begin : g_walk_chk
        assert_step_walk_R3: assert property (@(posedge clk) disable iff (rst)
            seq_step[i] |=> seq_step[i+1]);
    end

    assert_restore_R4: assert property (@(posedge clk) disable iff (rst)
        seq_step[SEQ_LEN-1] |=> (!ctrl_en_o && ser_ratio_o == RATIO_DFLT && !serial_sel_o));

    assert_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        ((|seq_step) && !seq_step[SEQ_LEN-1]) |=>
            ($stable(ctrl_en_o) && $stable(ser_ratio_o) && $stable(serial_sel_o)));

    assert_no_restart_R5: assert property (@(posedge clk) disable iff (rst)
        (|seq_step) |-> !seq_start);

    assert_passthru_R8: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en_o |-> (cpu_int_o == irq0_in && !serial_sel_o));

    assert_mixed_direct_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl_en_o && !serial_sel_o) |-> (cpu_int_o == direct_int_in));

    assert_mixed_serial_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl_en_o && serial_sel_o) |-> (cpu_int_o == serial_int_in));

endmodule

bind irqc_global_ctl irqc_global_ctl_chk i_chk (
    .clk           (clk),
    .rst           (rst),
    .seq_start     (seq_start),
    .seq_step      (seq_step),
    .irq0_in       (irq0_in),
    .direct_int_in (direct_int_in),
    .serial_int_in (serial_int_in),
    .cpu_int_o     (cpu_int_o),
    .ctrl_en_o     (ctrl_en_o),
    .serial_sel_o  (serial_sel_o),
    .ser_ratio_o   (ser_ratio_o)
);

// File: tb/test_irqc_global_ctl.sv
`timescale 1ns/1ps
module test_irqc_global_ctl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq0_in = 1'b0, direct_int_in = 1'b0, serial_int_in = 1'b0;
    logic        cpu_int_o, ctrl_en_o, serial_sel_o;
    logic [2:0]  ser_ratio_o;
    logic        clr_pend_o, clr_insvc_o, set_mask_o, tmr_halt_o, prio_load_o, spur_load_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irqc_global_ctl #(.ADDR_W(4)) i_irqc_global_ctl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq0_in(irq0_in),
        .direct_int_in(direct_int_in), .serial_int_in(serial_int_in),
        .cpu_int_o(cpu_int_o), .ctrl_en_o(ctrl_en_o), .serial_sel_o(serial_sel_o),
        .ser_ratio_o(ser_ratio_o), .clr_pend_o(clr_pend_o), .clr_insvc_o(clr_insvc_o),
        .set_mask_o(set_mask_o), .tmr_halt_o(tmr_halt_o), .prio_load_o(prio_load_o),
        .spur_load_o(spur_load_o)
    );

    // {mode, sel, irq0, direct, serial, expected cpu_int}
    localparam logic [5:0] ROUTE_VEC [8] = '{
        6'b0_0_1_0_0_1, 6'b0_0_0_1_1_0, 6'b0_1_1_0_0_1, 6'b0_1_0_1_1_0,
        6'b1_0_0_1_0_1, 6'b1_0_1_0_1_0, 6'b1_1_0_0_1_1, 6'b1_1_1_1_0_0
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, req, act, exp);
    endtask

    function automatic logic [5:0] strobes();
        return {clr_pend_o, clr_insvc_o, set_mask_o, tmr_halt_o, prio_load_o, spur_load_o};
    endfunction

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        bus_rd(4'd0, rd); check_eq("R1 gcr reset", rd, 32'h0000_0000);
        bus_rd(4'd1, rd); check_eq("R1 icr reset", rd, 32'h4000_0000);
        check_eq("R1 strobes idle", {26'd0, strobes()}, 32'd0);
        check_eq("R1 ctrl_en/ratio", {28'd0, ctrl_en_o, ser_ratio_o}, {28'd0, 1'b0, 3'd4});

        // R6, R7: field access, reserved bits read zero
        bus_wr(4'd0, 32'h7FFF_FFFF);
        bus_rd(4'd0, rd); check_eq("R6 mode rw", rd, 32'h2000_0000);
        bus_wr(4'd1, 32'hFFFF_FFFF);
        bus_rd(4'd1, rd); check_eq("R7 icr all ones", rd, 32'h7800_0000);
        check_eq("R7 ratio out", {29'd0, ser_ratio_o}, 32'd7);
        bus_wr(4'd1, 32'h2000_0000);
        bus_rd(4'd1, rd); check_eq("R7 icr ratio 2", rd, 32'h2000_0000);
        check_eq("R7 ratio out 2", {29'd0, ser_ratio_o}, 32'd2);

        // R10: unmapped address
        bus_wr(4'd5, 32'hFFFF_FFFF);
        bus_rd(4'd5, rd); check_eq("R10 unmapped read", rd, 32'h0);
        bus_rd(4'd0, rd); check_eq("R10 gcr untouched", rd, 32'h2000_0000);
        bus_rd(4'd1, rd); check_eq("R10 icr untouched", rd, 32'h2000_0000);

        // R8, R9: routing table
        for (int i = 0; i < 8; i++) begin
            logic [5:0] v;
            v = ROUTE_VEC[i];
            bus_wr(4'd0, {2'b00, v[5], 29'd0});
            bus_wr(4'd1, {4'b0100, v[4], 27'd0});
            irq0_in = v[3]; direct_int_in = v[2]; serial_int_in = v[1];
            #1;
            if (v[5]) begin
                check_eq("R9 cpu_int mixed", {31'd0, cpu_int_o}, {31'd0, v[0]});
                check_eq("R9 en/sel", {30'd0, ctrl_en_o, serial_sel_o}, {30'd0, 1'b1, v[4]});
            end else begin
                check_eq("R8 cpu_int pass", {31'd0, cpu_int_o}, {31'd0, v[0]});
                check_eq("R8 en/sel", {30'd0, ctrl_en_o, serial_sel_o}, 32'd0);
                irq0_in = ~v[3];
                #1;
                check_eq("R8 comb follow", {31'd0, cpu_int_o}, {31'd0, ~v[3]});
            end
        end

        // R2..R5: soft reset from a non-default setup
        bus_wr(4'd0, 32'h2000_0000);
        bus_wr(4'd1, 32'h5800_0000);
        bus_rd(4'd1, rd); check_eq("R7 setup", rd, 32'h5800_0000);
        bus_wr(4'd0, 32'h8000_0000);
        // cycle 1
        bus_rd(4'd0, rd); check_eq("R2 busy cyc1", rd, 32'hA000_0000);
        check_eq("R3 step1", {26'd0, strobes()}, 32'b110000);
        bus_addr = 4'd1; bus_wdata = 32'h0; bus_we = 1'b1;
        // cycle 2
        @(negedge clk);
        bus_rd(4'd1, rd); check_eq("R5 icr write ignored", rd, 32'h5800_0000);
        check_eq("R3 step2", {26'd0, strobes()}, 32'b001000);
        bus_addr = 4'd0; bus_wdata = 32'hA000_0000;
        // cycle 3
        @(negedge clk);
        bus_we = 1'b0;
        bus_rd(4'd0, rd); check_eq("R2 busy cyc3", rd, 32'hA000_0000);
        check_eq("R3 step3", {26'd0, strobes()}, 32'b000100);
        // cycle 4
        @(negedge clk);
        bus_rd(4'd0, rd); check_eq("R2 busy cyc4", rd, 32'hA000_0000);
        check_eq("R3 step4", {26'd0, strobes()}, 32'b000011);
        // done
        @(negedge clk);
        bus_rd(4'd0, rd); check_eq("R2 R4 R5 gcr after", rd, 32'h0000_0000);
        check_eq("R3 idle after", {26'd0, strobes()}, 32'd0);
        bus_rd(4'd1, rd); check_eq("R4 icr restore keeps sel", rd, 32'h4800_0000);
        check_eq("R4 ratio out", {28'd0, ctrl_en_o, ser_ratio_o}, {28'd0, 1'b0, 3'd4});
        @(negedge clk);
        check_eq("R5 no restart", {26'd0, strobes()}, 32'd0);

        // R1: hardware reset over programmed state
        bus_wr(4'd0, 32'h2000_0000);
        bus_wr(4'd1, 32'h7800_0000);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        bus_rd(4'd0, rd); check_eq("R1 gcr re-reset", rd, 32'h0);
        bus_rd(4'd1, rd); check_eq("R1 icr re-reset", rd, 32'h4000_0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule